// File: doc/BRIEF.md
# Per-Pin Interrupt Detector for a General-Purpose I/O Port

This block watches every input pin of a general-purpose I/O port and decides, pin by pin, when that pin asks for attention. Each pin has three configuration bits. The first chooses level or edge triggering. The second chooses one edge or both edges. The third chooses the polarity: high level or rising edge, or else low level or falling edge. Each pin input passes through a two-flop synchroniser. The block finds an edge by comparing the newest synchronised sample with the one before it.

A detected edge sets a sticky bit in an edge-status register, and software clears that bit by writing a 1 to it. The raw status shows the live condition for level pins and the sticky edge bit for edge pins. The masked status is the raw status gated by a per-pin enable. One registered interrupt line is raised whenever any masked bit is set.

A single-cycle register port gives access to all seven registers. Writes are strobed by the write enable and take effect on the clock edge. Reads are combinational from the byte address.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the sense, both-edge, polarity, enable, raw, masked and edge-status registers read zero, and `irq` is low.
- R2: A pin whose sense bit is 1 is level-triggered. Its raw bit equals the synchronised pin when its polarity bit is 1, and the inverted synchronised pin when its polarity bit is 0.
- R3: A pin whose sense bit is 0 and both-edge bit is 0 sets its edge-status bit on a rising edge if its polarity bit is 1, or on a falling edge if its polarity bit is 0. Its raw bit equals that sticky bit.
- R4: A pin whose sense bit is 0 and both-edge bit is 1 sets its edge-status bit on either transition, and its polarity bit has no effect.
- R5: Writing the edge-status register clears each bit written as 1. Bits written as 0 keep their value.
- R6: The masked status equals the raw status AND the enable register.
- R7: `irq` is a register that goes high one clock after any masked bit is set, and low one clock after none is set.
- R8: The byte offsets are: sense 0x34, both-edge 0x38, polarity 0x3C, enable 0x40, raw 0x44, masked 0x48, edge-status 0x4C. Raw and masked are read-only, so writes to them are ignored. Any other offset reads zero.
- R9: A pin whose sense bit is 1 never sets its edge-status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | N_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | N_PINS | Write data |
| rdata | output | N_PINS | Read data for `addr` |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with `N_PINS = 4`. With four pins it can give the pins different configurations in a rotating pattern and cover all eight configuration codes in eight passes. For each pass it sweeps every 4-bit start pattern against every 4-bit end pattern. So every pin sees every transition, and no transition, under every trigger mode. Each case also applies a partial write-one-to-clear with a different mask, and the enable pattern changes across passes.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  output logic              irq
);
  localparam logic [7:0] A_SENSE = 8'h34;
  localparam logic [7:0] A_BOTH  = 8'h38;
  localparam logic [7:0] A_POL   = 8'h3C;
  localparam logic [7:0] A_EN    = 8'h40;
  localparam logic [7:0] A_RAW   = 8'h44;
  localparam logic [7:0] A_MASK  = 8'h48;
  localparam logic [7:0] A_EDGE  = 8'h4C;

  logic [N_PINS-1:0] sense, both, pol, en;
  logic [N_PINS-1:0] sync1, sync2, prev;
  logic [N_PINS-1:0] edge_st, hit, clr, raw, masked;
  logic [N_PINS-1:0] rise, fall, level;

  assign rise   = sync2 & ~prev;
  assign fall   = ~sync2 & prev;
  assign hit    = ~sense & ((both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall))));
  assign level  = ~(pol ^ sync2);
  assign raw    = (sense & level) | (~sense & edge_st);
  assign masked = raw & en;
  assign clr    = (wr_en && addr == A_EDGE) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
      edge_st <= '0; irq <= 1'b0;
    end else begin
      sync1   <= pin_in;
      sync2   <= sync1;
      prev    <= sync2;
      edge_st <= (edge_st & ~clr) | hit;
      irq     <= |masked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0; both <= '0; pol <= '0; en <= '0;
    end else if (wr_en) begin
      case (addr)
        A_SENSE: sense <= wdata;
        A_BOTH:  both  <= wdata;
        A_POL:   pol   <= wdata;
        A_EN:    en    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_SENSE: rdata = sense;
      A_BOTH:  rdata = both;
      A_POL:   rdata = pol;
      A_EN:    rdata = en;
      A_RAW:   rdata = raw;
      A_MASK:  rdata = masked;
      A_EDGE:  rdata = edge_st;
      default: rdata = '0;
    endcase
  end

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|masked) |=> irq);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|masked) |=> !irq);
  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_EDGE) |=> ((edge_st & $past(edge_st)) == $past(edge_st)));
  p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_st & ~$past(edge_st) & ~($past(sync2) ^ $past(prev))) == '0));
  p_level_no_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_st & ~$past(edge_st) & $past(sense)) == '0));
endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [N-1:0] pin_in = '0, wdata = '0, rdata;
  logic [7:0] addr = 8'h00;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  gpio_irq_detect #(.N_PINS(N)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, s, b, p, en, rise, fall, hit, edge_e, raw_e, msk_e;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(8'h34, v); chk("R1 sense", v, '0);
    rd(8'h38, v); chk("R1 both", v, '0);
    rd(8'h3C, v); chk("R1 pol", v, '0);
    rd(8'h40, v); chk("R1 en", v, '0);
    rd(8'h44, v); chk("R1 raw", v, '0);
    rd(8'h48, v); chk("R1 masked", v, '0);
    rd(8'h4C, v); chk("R1 edge", v, '0);
    chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);

    // R8 map readback, read-only and unmapped
    wr(8'h40, 4'b1010); rd(8'h40, v); chk("R8 enable readback", v, 4'b1010);
    wr(8'h44, 4'b1111); rd(8'h44, v); chk("R8 raw write ignored", v, '0);
    wr(8'h48, 4'b1111); rd(8'h48, v); chk("R8 masked write ignored", v, '0);
    wr(8'h00, 4'b1111); rd(8'h00, v); chk("R8 unmapped reads zero", v, '0);
    rd(8'h50, v); chk("R8 unmapped 0x50 reads zero", v, '0);

    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = (k + i) % 8;
        s[i] = c[2]; b[i] = c[1]; p[i] = c[0];
      end
      en = {k[0], k[1], ~k[0], 1'b1};
      wr(8'h34, s); wr(8'h38, b); wr(8'h3C, p); wr(8'h40, en);
      rd(8'h3C, v); chk("R8 polarity readback", v, p);
      for (int a = 0; a < 16; a++) begin
        for (int e = 0; e < 16; e++) begin
          @(negedge clk); pin_in = a[N-1:0];
          idle(5);
          wr(8'h4C, '1);
          pin_in = e[N-1:0];
          idle(5);
          rise = ~a[N-1:0] & e[N-1:0];
          fall = a[N-1:0] & ~e[N-1:0];
          hit = (b & (rise | fall)) | (~b & ((p & rise) | (~p & fall)));
          edge_e = ~s & hit;
          raw_e = (s & ~(p ^ e[N-1:0])) | (~s & edge_e);
          msk_e = raw_e & en;
          rd(8'h4C, v); chk("R3/R4/R9 edge status", v, edge_e);
          rd(8'h44, v); chk("R2/R3/R4 raw", v, raw_e);
          rd(8'h48, v); chk("R6 masked", v, msk_e);
          chk("R7 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |msk_e});
          wr(8'h4C, e[N-1:0] ^ a[N-1:0] ^ k[N-1:0]);
          @(negedge clk);
          rd(8'h4C, v);
          chk("R5 partial clear", v, edge_e & ~(e[N-1:0] ^ a[N-1:0] ^ k[N-1:0]));
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule